// File: doc/BRIEF.md
# Banked Parallel Element-wise Map Engine

The engine applies one binary operation, addition or multiplication, to every element of an input array. Each result is written to the same position of an output array of equal length. Both arrays live in `NUM_BANKS` separate memory banks of `ARRAY_LEN / NUM_BANKS` words each. One lane is built per bank, and all lanes walk their banks at the same time. Each lane has its own index register, its own bound compare and its own arithmetic unit. The second operand is either the word at the same index of a second input array or a constant.

A run begins when `start` is seen while the engine is idle. At that moment the operator select, the operand-source select and the constant are captured. The controller has three states:

- `C_IDLE`: waiting for `start`.
- `C_RUN`: lanes are working.
- `C_DONE`: a one-cycle completion state.

The transitions are `C_IDLE -> C_RUN` on `start`, `C_RUN -> C_DONE` once every lane reports finished, and `C_DONE -> C_IDLE` unconditionally.

Each lane has five states:

- `L_IDLE`: waiting for the launch.
- `L_TEST`: compares the index with the bank length, and issues the read when the index is in range.
- `L_BODY`: computes the result from the returned data and writes it.
- `L_STEP`: increments the index.
- `L_FIN`: the lane has finished.

The lane transitions are as follows:

- `L_IDLE -> L_TEST` on launch, which clears the index.
- `L_TEST -> L_BODY` when the index is below the bank length.
- `L_TEST -> L_FIN` when the index has reached the bank length.
- `L_BODY -> L_STEP` always.
- `L_STEP -> L_TEST` always.
- `L_FIN -> L_IDLE` when the controller is in `C_DONE`.

Memories answer a read one cycle after the read enable.

Top module: `pmap_engine`

## Requirements
- R1: During and straight after reset, `busy`, `done` and every read and write enable are 0.
- R2: With `cfg_mul`=0 and `cfg_use_const`=0, each output word k of bank i equals the sum, modulo 2^32, of word k of input bank i in both arrays.
- R3: With `cfg_mul`=1, each output word is the lower 32 bits of the product of its two operands.
- R4: With `cfg_use_const`=1, the second operand is `cfg_const` for every element.
- R5: Each lane writes only into its own output bank. It writes addresses 0 to bank length minus 1 once each, in increasing order. Each write goes to the address read one cycle earlier.
- R6: `busy` is 1 from the cycle after `start` is accepted until the engine returns to idle. `done` is 1 for exactly one cycle, 3*(ARRAY_LEN/NUM_BANKS)+2 clock edges after the edge that accepted `start`. It rises only after every lane has finished.
- R7: A `start` pulse while `busy` is 1 is ignored. No second run and no second `done` pulse follow.
- R8: The configuration inputs are captured only on the accepting edge. Changes to them during a run do not alter the results.
- R9: When the constant is selected, `b_rd_en` is never asserted. Otherwise, exactly ARRAY_LEN reads of the second array occur per run.
- R10: In the cycle after `done`, the engine is idle and can accept a new `start` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, honoured only when idle |
| cfg_mul | input | 1 | 1 = multiply, 0 = add |
| cfg_use_const | input | 1 | 1 = second operand is cfg_const |
| cfg_const | input | 32 | Constant second operand |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| a_rd_en | output | NUM_BANKS | Read enable per first-array bank |
| a_rd_addr | output | NUM_BANKS*32 | Read index per bank, bank i in bits [32i+31:32i] |
| a_rd_data | input | NUM_BANKS*32 | Read data per bank, one cycle after enable |
| b_rd_en | output | NUM_BANKS | Read enable per second-array bank |
| b_rd_addr | output | NUM_BANKS*32 | Read index per second-array bank |
| b_rd_data | input | NUM_BANKS*32 | Second-array read data |
| y_wr_en | output | NUM_BANKS | Write enable per output bank |
| y_wr_addr | output | NUM_BANKS*32 | Write index per output bank |
| y_wr_data | output | NUM_BANKS*32 | Write data per output bank |

## Verification
The embedded properties watch the following on every cycle:

- the ordering inside each lane: a write always follows a read of the same index, write indices stay inside the bank, and the index only clears or steps by one;
- that a finished lane holds until release;
- that `done` lasts one cycle and follows the finish of every lane;
- that the captured configuration does not move during a run.

The arithmetic results, the exact completion latency, the per-bank write counts, the silence of the second array in constant mode, and the effect of stray `start` pulses and configuration changes mid-run can only be shown by the bench's directed scenarios against its memory models.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 32;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [2:0] {
        L_IDLE,
        L_TEST,
        L_BODY,
        L_STEP,
        L_FIN
    } lane_st_t;

    typedef enum logic [1:0] {
        C_IDLE,
        C_RUN,
        C_DONE
    } ctrl_st_t;

    typedef struct packed {
        logic  mul;
        logic  use_const;
        word_t konst;
    } op_cfg_t;
endpackage

// File: rtl/pmap_alu.sv
module pmap_alu
    import pmap_pkg::*;
(
    input  logic  mul,
    input  word_t opa,
    input  word_t opb,
    output word_t res
);
    // Both results wrap at 32 bits; the product keeps its lower half.
    always_comb begin
        if (mul) begin
            res = opa * opb;
        end else begin
            res = opa + opb;
        end
    end
endmodule

// File: rtl/pmap_lane.sv
module pmap_lane
    import pmap_pkg::*;
#(
    parameter int BANK_LEN = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  logic    release_i,
    input  op_cfg_t cfg,
    input  word_t   a_rd_data,
    input  word_t   b_rd_data,
    output logic    a_rd_en,
    output logic    b_rd_en,
    output idx_t    rd_addr,
    output logic    wr_en,
    output idx_t    wr_addr,
    output word_t   wr_data,
    output logic    fin
);
    localparam idx_t LEN_W = IDX_W'(BANK_LEN);

    lane_st_t st_q, st_nx;
    idx_t     idx_q;
    logic     in_range;
    logic     clr_idx;
    logic     bump;
    word_t    opb;

    assign in_range = (idx_q < LEN_W);

    // State and index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= L_IDLE;
            idx_q <= '0;
        end else begin
            st_q <= st_nx;
            if (clr_idx) begin
                idx_q <= '0;
            end else if (bump) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Next state.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            L_IDLE: if (go) st_nx = L_TEST;
            L_TEST: st_nx = in_range ? L_BODY : L_FIN;
            L_BODY: st_nx = L_STEP;
            L_STEP: st_nx = L_TEST;
            L_FIN:  if (release_i) st_nx = L_IDLE;
            default: st_nx = L_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        a_rd_en = 1'b0;
        b_rd_en = 1'b0;
        wr_en   = 1'b0;
        bump    = 1'b0;
        fin     = 1'b0;
        clr_idx = 1'b0;
        unique case (st_q)
            L_IDLE: clr_idx = go;
            L_TEST: begin
                a_rd_en = in_range;
                b_rd_en = in_range && !cfg.use_const;
            end
            L_BODY: wr_en = 1'b1;
            L_STEP: bump  = 1'b1;
            L_FIN:  fin   = 1'b1;
            default: ;
        endcase
    end

    assign opb     = cfg.use_const ? cfg.konst : b_rd_data;
    assign rd_addr = idx_q;
    assign wr_addr = idx_q;

    pmap_alu u_alu (
        .mul (cfg.mul),
        .opa (a_rd_data),
        .opb (opb),
        .res (wr_data)
    );

    // R5: a write always lands on the index read one cycle earlier
    p_wr_follows_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(a_rd_en) && $past(rd_addr) == wr_addr));

    // R5: writes stay inside the bank
    p_wr_in_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < LEN_W));

    // R5: the index only clears or advances by one
    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != $past(idx_q)) |-> (idx_q == '0 || idx_q == $past(idx_q) + 1'b1));

    // R6: a finished lane holds until the controller releases it
    p_fin_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !release_i) |=> fin);
endmodule

// File: rtl/pmap_ctrl.sv
module pmap_ctrl
    import pmap_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  op_cfg_t              cfg_in,
    input  logic [NUM_BANKS-1:0] lane_fin,
    output logic                 go,
    output logic                 release_o,
    output logic                 busy,
    output logic                 done,
    output op_cfg_t              cfg_q
);
    ctrl_st_t st_q, st_nx;
    logic     all_fin;

    assign all_fin = &lane_fin;

    // State and captured configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= C_IDLE;
            cfg_q <= '0;
        end else begin
            st_q <= st_nx;
            if (go) begin
                cfg_q <= cfg_in;
            end
        end
    end

    // Next state.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            C_IDLE: if (start) st_nx = C_RUN;
            C_RUN:  if (all_fin) st_nx = C_DONE;
            C_DONE: st_nx = C_IDLE;
            default: st_nx = C_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        go        = 1'b0;
        release_o = 1'b0;
        busy      = 1'b1;
        unique case (st_q)
            C_IDLE: begin
                go   = start;
                busy = 1'b0;
            end
            C_RUN:  ;
            C_DONE: release_o = 1'b1;
            default: ;
        endcase
    end

    assign done = release_o;

    // R6: done lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done follows the finish of every lane
    p_done_after_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(all_fin));

    // R8: the captured configuration does not move once a run is under way
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_q));
endmodule

// File: rtl/pmap_engine.sv
module pmap_engine
    import pmap_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ARRAY_LEN = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        cfg_mul,
    input  logic                        cfg_use_const,
    input  logic [31:0]                 cfg_const,
    output logic                        busy,
    output logic                        done,
    output logic [NUM_BANKS-1:0]        a_rd_en,
    output logic [NUM_BANKS*IDX_W-1:0]  a_rd_addr,
    input  logic [NUM_BANKS*WORD_W-1:0] a_rd_data,
    output logic [NUM_BANKS-1:0]        b_rd_en,
    output logic [NUM_BANKS*IDX_W-1:0]  b_rd_addr,
    input  logic [NUM_BANKS*WORD_W-1:0] b_rd_data,
    output logic [NUM_BANKS-1:0]        y_wr_en,
    output logic [NUM_BANKS*IDX_W-1:0]  y_wr_addr,
    output logic [NUM_BANKS*WORD_W-1:0] y_wr_data
);
    localparam int BANK_LEN = ARRAY_LEN / NUM_BANKS;

    if (NUM_BANKS < 1 || (ARRAY_LEN % NUM_BANKS) != 0) begin : g_bad_split
        $error("ARRAY_LEN must be a whole multiple of NUM_BANKS");
    end

    op_cfg_t              cfg_in, cfg_q;
    logic                 go, release_w;
    logic [NUM_BANKS-1:0] lane_fin;

    assign cfg_in = '{mul: cfg_mul, use_const: cfg_use_const, konst: cfg_const};

    pmap_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_in    (cfg_in),
        .lane_fin  (lane_fin),
        .go        (go),
        .release_o (release_w),
        .busy      (busy),
        .done      (done),
        .cfg_q     (cfg_q)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_lane
        idx_t raddr;

        pmap_lane #(.BANK_LEN(BANK_LEN)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .go        (go),
            .release_i (release_w),
            .cfg       (cfg_q),
            .a_rd_data (a_rd_data[i*WORD_W +: WORD_W]),
            .b_rd_data (b_rd_data[i*WORD_W +: WORD_W]),
            .a_rd_en   (a_rd_en[i]),
            .b_rd_en   (b_rd_en[i]),
            .rd_addr   (raddr),
            .wr_en     (y_wr_en[i]),
            .wr_addr   (y_wr_addr[i*IDX_W +: IDX_W]),
            .wr_data   (y_wr_data[i*WORD_W +: WORD_W]),
            .fin       (lane_fin[i])
        );

        assign a_rd_addr[i*IDX_W +: IDX_W] = raddr;
        assign b_rd_addr[i*IDX_W +: IDX_W] = raddr;
    end
endmodule

// File: tb/tb_pmap_engine.sv
module tb_pmap_engine;
    localparam int B  = 4;
    localparam int L  = 16;
    localparam int BL = L / B;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              cfg_mul = 1'b0;
    logic              cfg_use_const = 1'b0;
    logic [31:0]       cfg_const = '0;
    logic              busy, done;
    logic [B-1:0]      a_rd_en, b_rd_en, y_wr_en;
    logic [B*32-1:0]   a_rd_addr, b_rd_addr, y_wr_addr, y_wr_data;
    logic [B*32-1:0]   a_rd_data = '0;
    logic [B*32-1:0]   b_rd_data = '0;

    logic [31:0] a_mem [B][BL];
    logic [31:0] b_mem [B][BL];
    logic [31:0] y_mem [B][BL];
    int wcnt [B];
    int ord_err = 0;
    int b_rd_cnt = 0;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pmap_engine #(.NUM_BANKS(B), .ARRAY_LEN(L)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mul(cfg_mul),
        .cfg_use_const(cfg_use_const), .cfg_const(cfg_const),
        .busy(busy), .done(done),
        .a_rd_en(a_rd_en), .a_rd_addr(a_rd_addr), .a_rd_data(a_rd_data),
        .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
        .y_wr_en(y_wr_en), .y_wr_addr(y_wr_addr), .y_wr_data(y_wr_data)
    );

    initial begin
        for (int i = 0; i < B; i++) wcnt[i] = 0;
    end

    // Memory models with one-cycle read latency, plus write monitor.
    always @(posedge clk) begin
        for (int i = 0; i < B; i++) begin
            int ra, wa;
            ra = int'(a_rd_addr[i*32 +: 32]);
            if (a_rd_en[i] && ra < BL) a_rd_data[i*32 +: 32] <= a_mem[i][ra];
            ra = int'(b_rd_addr[i*32 +: 32]);
            if (b_rd_en[i]) begin
                b_rd_cnt = b_rd_cnt + 1;
                if (ra < BL) b_rd_data[i*32 +: 32] <= b_mem[i][ra];
            end
            if (y_wr_en[i]) begin
                wa = int'(y_wr_addr[i*32 +: 32]);
                if (wa != wcnt[i]) ord_err = ord_err + 1;
                if (wa < BL) y_mem[i][wa] <= y_wr_data[i*32 +: 32];
                wcnt[i] = wcnt[i] + 1;
            end
            if (done) wcnt[i] = 0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill(input int seed, input bit big);
        for (int i = 0; i < B; i++) begin
            for (int j = 0; j < BL; j++) begin
                if (big) begin
                    a_mem[i][j] = 32'hF000_0001 + 32'(seed * (i * BL + j + 3));
                    b_mem[i][j] = 32'h8000_0003 + 32'(seed * 7 * (i + 1) + j);
                end else begin
                    a_mem[i][j] = 32'(seed * 100 + i * BL + j);
                    b_mem[i][j] = 32'(seed * 1000 + 3 * (i * BL + j) + 1);
                end
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
        chk(a_rd_en == 0 && b_rd_en == 0 && y_wr_en == 0, "R1 enables in reset",
            {a_rd_en, b_rd_en, y_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && y_wr_en == 0 && a_rd_en == 0, "R1 after reset",
            {busy, done, a_rd_en, y_wr_en}, 0);
    endtask

    task automatic run_case(input string rt, input logic mul, input logic uc,
                            input logic [31:0] k, input bit disturb);
        int cyc, base_b, base_o, busy_low, done_cnt;
        bit seen;
        @(negedge clk);
        cfg_mul = mul; cfg_use_const = uc; cfg_const = k; start = 1'b1;
        base_b = b_rd_cnt; base_o = ord_err;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; seen = 0; busy_low = 0;
        if (disturb) begin
            cfg_mul = ~mul; cfg_use_const = ~uc; cfg_const = k + 77;
        end
        chk(busy, "R6 busy after accept", busy, 1);
        while (!seen && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 3) start = 1'b1;
            if (disturb && cyc == 5) start = 1'b0;
            if (!busy) busy_low++;
            if (done) seen = 1;
        end
        chk(cyc == 3 * BL + 2, "R6 done latency", cyc, 3 * BL + 2);
        chk(busy_low == 0, "R6 busy held during run", busy_low, 0);
        for (int i = 0; i < B; i++)
            chk(wcnt[i] == BL, "R5 writes per bank", wcnt[i], BL);
        chk(ord_err == base_o, "R5 write order", ord_err - base_o, 0);
        if (uc) chk(b_rd_cnt == base_b, "R9 no second-array reads", b_rd_cnt - base_b, 0);
        else    chk(b_rd_cnt - base_b == L, "R9 second-array reads", b_rd_cnt - base_b, L);
        @(negedge clk);
        chk(!done, "R6 done one cycle", done, 0);
        chk(!busy, "R10 idle after done", busy, 0);
        for (int i = 0; i < B; i++) begin
            int nbad;
            logic [31:0] fa, fe;
            nbad = 0; fa = '0; fe = '0;
            for (int j = 0; j < BL; j++) begin
                logic [31:0] ob, e;
                ob = uc ? k : b_mem[i][j];
                e  = mul ? a_mem[i][j] * ob : a_mem[i][j] + ob;
                if (y_mem[i][j] !== e) begin
                    if (nbad == 0) begin fa = y_mem[i][j]; fe = e; end
                    nbad++;
                end
            end
            chk(nbad == 0, {rt, " bank results"}, fa, fe);
        end
        if (disturb) begin
            done_cnt = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (done || busy) done_cnt++;
            end
            chk(done_cnt == 0, "R7 no second run from stray start", done_cnt, 0);
        end
        cfg_mul = 1'b0; cfg_use_const = 1'b0; cfg_const = '0;
    endtask

    initial begin
        fill(1, 1'b0);
        t_reset();
        fill(1, 1'b0);
        run_case("R2", 1'b0, 1'b0, 32'd0, 1'b0);
        fill(3, 1'b1);
        run_case("R3", 1'b1, 1'b0, 32'd0, 1'b0);
        fill(4, 1'b0);
        run_case("R4", 1'b0, 1'b1, 32'd5, 1'b0);
        fill(5, 1'b1);
        run_case("R4", 1'b1, 1'b1, 32'h9ABC_DEF1, 1'b0);
        fill(6, 1'b0);
        run_case("R8", 1'b0, 1'b0, 32'd0, 1'b1);
        fill(7, 1'b1);
        run_case("R10", 1'b0, 1'b1, 32'hFFFF_FFF0, 1'b0);
        fill(8, 1'b0);
        run_case("R10", 1'b1, 1'b0, 32'd0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule